// File: doc/BRIEF.md
# Base-Bound Address Translator

This block converts 32-bit virtual addresses into physical addresses without a page table or TLB. The low half of the address space belongs to user programs. Each access there is checked against a limit register and then shifted by an offset register. Instruction fetches use one limit/offset pair and loads and stores use another, so code and data of a task can live in separate physical regions. The upper half of the space is for the kernel only and has fixed mappings: two half-gigabyte windows that fold onto the bottom of physical memory (one cacheable, one not), and a one-gigabyte region that passes straight through.

A request enters with its address, a fetch-or-data flag and the current privilege mode. One clock later the block returns the physical address, a cacheable flag and a fault flag. When an access faults, the block latches the offending virtual address into a holding register that stays visible on a port. The four relocation registers are loaded through a simple write port that selects one register and writes its value.

Top module: `bb_xlate`

## Requirements
- R1: After reset, rsp_valid is 0, bad_vaddr is 0 and all four relocation registers are 0, so every user-half access faults.
- R2: A fetch (req_fetch=1) uses the instruction pair (cfg_sel 0 = offset, 1 = limit). A load or store (req_fetch=0) uses the data pair (cfg_sel 2 = offset, 3 = limit).
- R3: A user-half address (bit 31 = 0) below the selected limit translates to address + offset, taken modulo 2^32, with rsp_cached=1 and rsp_fault=0.
- R4: A user-half address equal to or above the selected limit gives rsp_fault=1, rsp_paddr=0 and rsp_cached=0. The address limit-1 is still accepted.
- R5: In user mode (req_user=1), any address with bit 31 set faults.
- R6: In kernel mode, addresses with top bits 100 map to the address with its top three bits cleared, with rsp_cached=1.
- R7: In kernel mode, addresses with top bits 101 map to the address with its top three bits cleared, with rsp_cached=0.
- R8: In kernel mode, addresses with top bits 11 pass through unchanged, with rsp_cached=1.
- R9: On a faulting access, bad_vaddr takes that virtual address in the same cycle the response appears. Accesses that do not fault leave bad_vaddr unchanged.
- R10: rsp_valid is 1 exactly one cycle after each cycle in which req_valid is 1, and 0 otherwise. Requests may arrive on back-to-back cycles.
- R11: A register write takes effect for requests issued in later cycles. A request issued in the same cycle as a write uses the old value.
- R12: Kernel-mode accesses to the user half are checked and relocated through the same registers as user-mode accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a relocation register |
| cfg_sel | input | 2 | Register select: 0 instr offset, 1 instr limit, 2 data offset, 3 data limit |
| cfg_wdata | input | 32 | Value to write |
| req_valid | input | 1 | A translation request is present |
| req_vaddr | input | 32 | Virtual address |
| req_fetch | input | 1 | 1 for an instruction fetch, 0 for a load or store |
| req_user | input | 1 | 1 in user mode, 0 in kernel mode |
| rsp_valid | output | 1 | A response is present |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_cached | output | 1 | The access is cacheable |
| rsp_fault | output | 1 | Address error |
| bad_vaddr | output | 32 | Virtual address of the latest fault |

## Verification
The bench uses the default ADDR_W of 32. With that width the exact segment edges can be tested: 0x7FFFFFFF, 0x80000000, 0x9FFFFFFF, 0xA0000000, 0xBFFFFFFF, 0xC0000000 and 0xFFFFFFFC. A limit of 0x80000000 makes the whole user half legal, and a large offset drives the relocation sum past 2^32 so that wrap-around is tested. A scoreboard holds one expected response per request and checks every idle cycle for an unwanted response. This covers back-to-back traffic and a register write that lands in the same cycle as a request.

// File: rtl/bbx_pkg.sv
package bbx_pkg;
  typedef enum logic [1:0] {
    SEG_USER   = 2'd0,
    SEG_KWIN_C = 2'd1,
    SEG_KWIN_U = 2'd2,
    SEG_KHIGH  = 2'd3
  } seg_e;

  typedef enum logic [1:0] {
    CFG_IOFS = 2'd0,
    CFG_ILIM = 2'd1,
    CFG_DOFS = 2'd2,
    CFG_DLIM = 2'd3
  } cfg_e;

  localparam int NUM_REGS = 4;
  localparam int WIN_BITS = 3;
endpackage

// File: rtl/bbx_regs.sv
module bbx_regs #(
  parameter int ADDR_W = 32,
  parameter int NREG   = bbx_pkg::NUM_REGS,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] regs [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (sel == SEL_W'(g)))
        regs[g] <= wdata;
    end
  end
endmodule

// File: rtl/bbx_seg_decode.sv
module bbx_seg_decode #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] va,
  output bbx_pkg::seg_e     seg
);
  import bbx_pkg::*;
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique casez (va[TOP -: WIN_BITS])
      3'b0??:  seg = SEG_USER;
      3'b100:  seg = SEG_KWIN_C;
      3'b101:  seg = SEG_KWIN_U;
      default: seg = SEG_KHIGH;
    endcase
  end
endmodule

// File: rtl/bbx_user_map.sv
module bbx_user_map #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] va,
  input  logic              fetch,
  input  logic [ADDR_W-1:0] iofs,
  input  logic [ADDR_W-1:0] ilim,
  input  logic [ADDR_W-1:0] dofs,
  input  logic [ADDR_W-1:0] dlim,
  output logic              in_bound,
  output logic [ADDR_W-1:0] paddr
);
  function automatic logic below_limit(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] lim);
    return a < lim;
  endfunction

  function automatic logic [ADDR_W-1:0] relocate(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] ofs);
    return a + ofs;
  endfunction

  logic [ADDR_W-1:0] sel_ofs, sel_lim;

  always_comb begin
    sel_ofs  = fetch ? iofs : dofs;
    sel_lim  = fetch ? ilim : dlim;
    in_bound = below_limit(va, sel_lim);
    paddr    = relocate(va, sel_ofs);
  end
endmodule

// File: rtl/bb_xlate.sv
module bb_xlate #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_fetch,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_cached,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] bad_vaddr
);
  import bbx_pkg::*;

  function automatic logic [ADDR_W-1:0] fold_window(input logic [ADDR_W-1:0] a);
    return {{WIN_BITS{1'b0}}, a[ADDR_W-WIN_BITS-1:0]};
  endfunction

  logic [ADDR_W-1:0] cfg_q [NUM_REGS];
  seg_e              seg;
  logic              in_bound;
  logic [ADDR_W-1:0] user_pa;
  logic              priv_viol;
  logic              bound_viol;
  logic              fault_n;
  logic              cached_n;
  logic [ADDR_W-1:0] paddr_n;

  bbx_regs #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .regs(cfg_q)
  );

  bbx_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .va(req_vaddr), .seg(seg)
  );

  bbx_user_map #(.ADDR_W(ADDR_W)) u_umap (
    .va(req_vaddr), .fetch(req_fetch),
    .iofs(cfg_q[CFG_IOFS]), .ilim(cfg_q[CFG_ILIM]),
    .dofs(cfg_q[CFG_DOFS]), .dlim(cfg_q[CFG_DLIM]),
    .in_bound(in_bound), .paddr(user_pa)
  );

  always_comb begin
    priv_viol  = req_user && (seg != SEG_USER);
    bound_viol = (seg == SEG_USER) && !in_bound;
    fault_n    = priv_viol || bound_viol;
    unique case (seg)
      SEG_USER:   begin paddr_n = user_pa;                cached_n = 1'b1; end
      SEG_KWIN_C: begin paddr_n = fold_window(req_vaddr); cached_n = 1'b1; end
      SEG_KWIN_U: begin paddr_n = fold_window(req_vaddr); cached_n = 1'b0; end
      default:    begin paddr_n = req_vaddr;              cached_n = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_cached <= 1'b0;
      rsp_fault  <= 1'b0;
      bad_vaddr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault  <= fault_n;
        rsp_paddr  <= fault_n ? '0 : paddr_n;
        rsp_cached <= fault_n ? 1'b0 : cached_n;
        if (fault_n)
          bad_vaddr <= req_vaddr;
      end
    end
  end
endmodule

// File: rtl/bbx_checker.sv
module bbx_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              req_user,
  input logic              in_bound,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_cached,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] bad_vaddr
);
  localparam int TOP = ADDR_W - 1;

  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r5_user_high_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && req_vaddr[TOP]) |=> rsp_fault);
  a_r3_in_bound_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_vaddr[TOP] && in_bound) |=> (!rsp_fault && rsp_cached));
  a_r4_fault_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_cached));
  a_r9_capture_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (bad_vaddr == $past(req_vaddr)));
  a_r9_hold_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> $stable(bad_vaddr));
  a_r6_cached_window: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_user && req_vaddr[TOP -: 3] == 3'b100)
      |=> (rsp_cached && rsp_paddr[TOP -: 3] == 3'b000));
  a_r7_uncached_window: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_user && req_vaddr[TOP -: 3] == 3'b101)
      |=> (!rsp_cached && !rsp_fault && rsp_paddr[TOP -: 3] == 3'b000));
  a_r8_high_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_user && req_vaddr[TOP -: 2] == 2'b11)
      |=> (rsp_cached && rsp_paddr == $past(req_vaddr)));
endmodule

bind bb_xlate bbx_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_user(req_user), .in_bound(in_bound), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_cached(rsp_cached), .rsp_fault(rsp_fault),
  .bad_vaddr(bad_vaddr)
);

// File: tb/sim_bb_xlate.sv
module sim_bb_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = 32'd0;
  logic        req_fetch = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid, rsp_cached, rsp_fault;
  logic [31:0] rsp_paddr, bad_vaddr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] pa;
    logic        cached;
    logic        fault;
    logic [31:0] bad;
    string       tag;
  } exp_t;

  exp_t q[$];

  logic [31:0] m_reg [4];
  logic [31:0] m_bad;

  always #4 clk = ~clk;

  bb_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_fetch(req_fetch), .req_user(req_user), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_cached(rsp_cached), .rsp_fault(rsp_fault),
    .bad_vaddr(bad_vaddr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] va, input bit fetch,
                                 input bit user, input string tag);
    exp_t e;
    logic [31:0] lim, ofs;
    e.tag = tag; e.fault = 0; e.cached = 1; e.pa = 0;
    lim = fetch ? m_reg[1] : m_reg[3];
    ofs = fetch ? m_reg[0] : m_reg[2];
    if (va < 32'h8000_0000) begin
      if (va >= lim) e.fault = 1;
      else e.pa = va + ofs;
    end else if (user) begin
      e.fault = 1;
    end else if (va < 32'hA000_0000) begin
      e.pa = va - 32'h8000_0000;
    end else if (va < 32'hC000_0000) begin
      e.pa = va - 32'hA000_0000; e.cached = 0;
    end else begin
      e.pa = va;
    end
    if (e.fault) begin e.cached = 0; e.pa = 0; end
    e.bad = e.fault ? va : m_bad;
    return e;
  endfunction

  task automatic send(input logic [31:0] va, input bit fetch, input bit user,
                      input string tag);
    exp_t e;
    e = model(va, fetch, user, tag);
    req_valid = 1; req_vaddr = va; req_fetch = fetch; req_user = user;
    @(posedge clk);
    q.push_back(e);
    m_bad = e.bad;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    m_reg[sel] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_with_write(input logic [1:0] sel, input logic [31:0] d,
                                 input logic [31:0] va, input bit fetch,
                                 input string tag);
    exp_t e;
    e = model(va, fetch, 0, tag);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    req_valid = 1; req_vaddr = va; req_fetch = fetch; req_user = 0;
    @(posedge clk);
    q.push_back(e);
    m_bad = e.bad;
    m_reg[sel] = d;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
  endtask

  // Monitor: one comparison per expected item, idle cycles must be quiet (R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(rsp_valid === 1'b1, e.tag, "rsp_valid (R10)", {31'd0, rsp_valid}, 32'd1);
        check(rsp_fault === e.fault, e.tag, "fault", {31'd0, rsp_fault}, {31'd0, e.fault});
        check(rsp_paddr === e.pa, e.tag, "paddr", rsp_paddr, e.pa);
        check(rsp_cached === e.cached, e.tag, "cached", {31'd0, rsp_cached}, {31'd0, e.cached});
        check(bad_vaddr === e.bad, e.tag, "bad_vaddr (R9)", bad_vaddr, e.bad);
      end else begin
        check(rsp_valid === 1'b0, "R10", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 32'd0;
    m_bad = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(rsp_valid === 1'b0, "R1", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check(bad_vaddr === 32'd0, "R1", "reset bad_vaddr", bad_vaddr, 32'd0);
    send(32'h0000_0100, 1, 1, "R1 zero limit fetch");
    send(32'h0000_0000, 0, 0, "R1 zero limit data");

    cfg_write(2'd0, 32'h1000_0000);
    cfg_write(2'd1, 32'h0001_0000);
    cfg_write(2'd2, 32'h2000_0000);
    cfg_write(2'd3, 32'h0000_8000);
    @(negedge clk);

    // R2 / R3: pair selection and relocation
    send(32'h0000_1234, 1, 1, "R2 R3 fetch reloc");
    send(32'h0000_1234, 0, 1, "R2 R3 data reloc");
    send(32'h0000_9000, 0, 1, "R2 data limit");
    send(32'h0000_9000, 1, 1, "R2 fetch limit");
    // R4: exact limit edge
    send(32'h0000_7FFF, 0, 1, "R4 limit-1");
    send(32'h0000_8000, 0, 1, "R4 at limit");
    send(32'h0000_FFFF, 1, 1, "R4 instr limit-1");
    send(32'h0001_0000, 1, 1, "R4 instr at limit");
    // R12: kernel access to the user half
    send(32'h0000_0040, 0, 0, "R12 kernel data reloc");
    send(32'h0000_8004, 0, 0, "R12 kernel data over");
    @(negedge clk);

    // R3 wrap and full user half
    cfg_write(2'd0, 32'hF000_0000);
    cfg_write(2'd1, 32'h8000_0000);
    send(32'h1000_0005, 1, 1, "R3 wrap");
    send(32'h7FFF_FFFF, 1, 1, "R3 top of user half");
    // R5
    send(32'h8000_0000, 1, 1, "R5 user kseg low");
    send(32'hA000_0000, 0, 1, "R5 user uncached win");
    send(32'hFFFF_FFFC, 0, 1, "R5 user top");
    // R6 / R7 / R8
    send(32'h8000_1234, 0, 0, "R6 cached window");
    send(32'h9FFF_FFFF, 1, 0, "R6 window top");
    send(32'hA000_0010, 0, 0, "R7 uncached window");
    send(32'hBFFF_FFFF, 0, 0, "R7 window top");
    send(32'hC000_0000, 0, 0, "R8 high base");
    send(32'hFFFF_FFFC, 1, 0, "R8 high top");
    @(negedge clk);
    @(negedge clk);

    // R11: write in same cycle as a request, then a later request
    send_with_write(2'd3, 32'h0001_0000, 32'h0000_9000, 0, "R11 same-cycle old limit");
    send(32'h0000_9000, 0, 1, "R11 new limit applied");
    send_with_write(2'd2, 32'h0300_0000, 32'h0000_0010, 0, "R11 same-cycle old offset");
    send(32'h0000_0010, 0, 0, "R11 new offset applied");
    repeat (3) @(negedge clk);

    check(q.size() == 0, "R10", "queue drained", q.size(), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule